// File: doc/BRIEF.md
# Receive Idle-Residue Ready Flag

This block raises a status flag for a UART receiver with a receive FIFO. The flag means that some bytes are sitting in the FIFO below the programmed trigger level and the line has been quiet for long enough that no more bytes are expected soon. A quiet timer counts bit-time ticks and restarts on every received stop bit. The flag sets when the timer has seen 15 quiet bit times while the FIFO holds between one byte and one byte fewer than the trigger count. At 8 data bits and one stop bit, that quiet window is about one and a half frames.

There are two ways to clear the flag. Software must read the flag while it is 1, empty the FIFO, and then write 0 to the flag. A DMA engine clears it by reading the FIFO until it is empty. A synchronous soft reset clears the flag, and so does the asynchronous reset. Every clear also restarts the quiet timer, so the flag can come back only after a new quiet window of 15 bit times.

The flag is held by a three-state machine:
- `FL_QUIET`: flag 0.
- `FL_HELD`: flag 1, no qualifying read seen yet.
- `FL_SEEN`: flag 1, read as 1 by software.

The transitions are:
- *raise* (QUIET→HELD): the window has elapsed and a residue is present.
- *acknowledge* (HELD→SEEN): a status read.
- *cpu-clear* (SEEN→QUIET): a write of 0 with the FIFO empty.
- *dma-clear* (HELD or SEEN→QUIET): a DMA read that leaves the FIFO empty.
- *abort* (any state→QUIET): soft reset.

An optional interrupt output mirrors the flag.

Top module: `rx_idle_ready`

## Requirements
- R1: After `rst_n` goes low, `ready_flag` and `ready_irq` are 0.
- R2: The quiet timer advances by one on each `bit_tick` cycle. The flag rises at the clock edge after the 15th tick following the last stop bit, and not before.
- R3: A `stop_seen` pulse restarts the quiet count from zero, so ticks from before the pulse do not count.
- R4: The flag does not set when `fifo_level` is 0 or when `fifo_level` is greater than or equal to `trig_level` (both unsigned), however long the line stays quiet.
- R5: The quiet count saturates at 15 and does not wrap. After any number of extra ticks, a level that drops into the residue range raises the flag at the next edge.
- R6: A write of 0 to the flag (`flag_wr`=1, `flag_wdata`=0) is ignored in these cases: no status read happened while the flag was 1, or the FIFO is not empty. A write of 1 never clears the flag. A status read taken while the flag is 0 does not count as a read.
- R7: While in the read state, a write of 0 in a cycle with `fifo_level`=0 clears the flag at the next edge.
- R8: Any clear restarts the quiet timer. Even when the residue condition holds again right away, the flag re-rises only after 15 new ticks.
- R9: `dma_rd` in a cycle with `fifo_level`=0 clears the flag at the next edge whether or not a read happened. `dma_rd` with a non-empty FIFO has no effect.
- R10: `soft_rst` clears the flag at the next edge.
- R11: With `GEN_IRQ`=1, `ready_irq` equals `ready_flag` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous soft reset of flag and timer |
| bit_tick | input | 1 | One-cycle pulse per elapsed bit time |
| stop_seen | input | 1 | Pulse when a frame's stop bit is received |
| fifo_level | input | LVL_W | Bytes currently in the receive FIFO |
| trig_level | input | LVL_W | Programmed receive trigger count |
| stat_rd | input | 1 | Software read of the status holding the flag |
| flag_wr | input | 1 | Software write strobe to the flag |
| flag_wdata | input | 1 | Value written to the flag |
| dma_rd | input | 1 | DMA read strobe of the receive FIFO |
| ready_flag | output | 1 | Idle-residue ready flag |
| ready_irq | output | 1 | Interrupt request (tied 0 when GEN_IRQ=0) |

## Verification
The flag is exercised against quiet windows of 14, 15 and more than 15 ticks. This separates an off-by-one threshold from a correct one, and a wrapping counter from a saturating one. Stop bits are placed inside a window to show that the count restarts rather than accumulates.

FIFO levels of 0, inside the residue range, equal to the trigger and above it tell the residue comparison apart from a plain non-empty test. Clear attempts that skip the read, or leave bytes in the FIFO, or write 1, are mixed with valid CPU and DMA clears. These show that only the full handshake drops the flag, and that a fresh window is then needed.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
    typedef enum logic [1:0] {
        FL_QUIET = 2'd0,
        FL_HELD  = 2'd1,
        FL_SEEN  = 2'd2
    } flag_st_e;
endpackage

// File: rtl/rxto_quiet_timer.sv
module rxto_quiet_timer #(
    parameter int IDLE_BITS = 15,
    localparam int CW = $clog2(IDLE_BITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic bit_tick,
    output logic idle_full
);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_BITS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart)
            cnt <= '0;
        else if (bit_tick && cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    assign idle_full = (cnt == LIMIT);

    // R5: once full, stays full until restarted
    assert_hold_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_full && !restart) |=> idle_full);
    // R3: restart empties the window
    assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !idle_full);
    // R2: no tick, no restart -> count holds
    assert_no_drift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !bit_tick) |=> $stable(cnt));
endmodule

// File: rtl/rxto_flag_fsm.sv
module rxto_flag_fsm
    import rxto_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             idle_full,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] trig_level,
    input  logic             stat_rd,
    input  logic             flag_wr,
    input  logic             flag_wdata,
    input  logic             dma_rd,
    output logic             flag,
    output logic             clr_evt
);
    flag_st_e st, st_nx;
    logic     residue, empty, cpu_clr, dma_clr;

    assign empty   = (fifo_level == '0);
    assign residue = !empty && (fifo_level < trig_level);
    assign cpu_clr = flag_wr && !flag_wdata && empty;
    assign dma_clr = dma_rd && empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= FL_QUIET;
        else
            st <= st_nx;
    end

    always_comb begin
        st_nx   = st;
        clr_evt = 1'b0;
        unique case (st)
            FL_QUIET: if (idle_full && residue) st_nx = FL_HELD;
            FL_HELD: begin
                if (dma_clr) begin
                    st_nx   = FL_QUIET;
                    clr_evt = 1'b1;
                end else if (stat_rd) begin
                    st_nx = FL_SEEN;
                end
            end
            FL_SEEN: begin
                if (cpu_clr || dma_clr) begin
                    st_nx   = FL_QUIET;
                    clr_evt = 1'b1;
                end
            end
            default: st_nx = FL_QUIET;
        endcase
        if (soft_rst) begin
            st_nx   = FL_QUIET;
            clr_evt = 1'b1;
        end
    end

    always_comb begin
        flag = (st != FL_QUIET);
    end

    // R4: a rise needs an elapsed window and a residue
    assert_rise_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(idle_full && residue));
    // R6: write of 0 before any read keeps the flag
    assert_wr_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FL_HELD && flag_wr && !dma_clr && !soft_rst) |=> flag);
    // R7: full handshake clears
    assert_cpu_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FL_SEEN && cpu_clr) |=> !flag);
    // R9: DMA drain clears
    assert_dma_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && dma_clr) |=> !flag);
    // R10: soft reset clears
    assert_soft_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !flag);
endmodule

// File: rtl/rx_idle_ready.sv
module rx_idle_ready #(
    parameter int LVL_W     = 5,
    parameter int IDLE_BITS = 15,
    parameter bit GEN_IRQ   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             bit_tick,
    input  logic             stop_seen,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] trig_level,
    input  logic             stat_rd,
    input  logic             flag_wr,
    input  logic             flag_wdata,
    input  logic             dma_rd,
    output logic             ready_flag,
    output logic             ready_irq
);
    logic idle_full;
    logic clr_evt;

    rxto_quiet_timer #(.IDLE_BITS(IDLE_BITS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (stop_seen | clr_evt),
        .bit_tick  (bit_tick),
        .idle_full (idle_full)
    );

    rxto_flag_fsm #(.LVL_W(LVL_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .idle_full  (idle_full),
        .fifo_level (fifo_level),
        .trig_level (trig_level),
        .stat_rd    (stat_rd),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .dma_rd     (dma_rd),
        .flag       (ready_flag),
        .clr_evt    (clr_evt)
    );

    generate
        if (GEN_IRQ) begin : g_irq
            assign ready_irq = ready_flag;
        end else begin : g_no_irq
            assign ready_irq = 1'b0;
        end
    endgenerate

    // R11: interrupt tracks the flag
    assert_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        GEN_IRQ |-> (ready_irq == ready_flag));
endmodule

// File: tb/sim_rx_idle_ready.sv
module sim_rx_idle_ready;
    localparam int LVL_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0, bit_tick = 1'b0, stop_seen = 1'b0;
    logic [LVL_W-1:0] fifo_level = '0, trig_level = 5'd4;
    logic stat_rd = 1'b0, flag_wr = 1'b0, flag_wdata = 1'b0, dma_rd = 1'b0;
    logic ready_flag, ready_irq;

    int n_total = 0, n_fail = 0;
    bit    q_exp[$];
    string q_tag[$];

    always #2.5 clk = ~clk;

    rx_idle_ready #(.LVL_W(LVL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bit_tick(bit_tick),
        .stop_seen(stop_seen), .fifo_level(fifo_level), .trig_level(trig_level),
        .stat_rd(stat_rd), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .dma_rd(dma_rd), .ready_flag(ready_flag), .ready_irq(ready_irq)
    );

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q_exp.size() > 0) begin
                bit    e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                n_total++;
                if (ready_flag !== e) begin
                    n_fail++;
                    $display("FAIL %s: ready_flag=%0b expected %0b", t, ready_flag, e);
                end
                n_total++;
                if (ready_irq !== e) begin
                    n_fail++;
                    $display("FAIL R11 (%s): ready_irq=%0b expected %0b", t, ready_irq, e);
                end
            end
        end
    end

    task automatic expect_flag(input bit e, input string tag);
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk) bit_tick = 1'b1;
            @(negedge clk) bit_tick = 1'b0;
        end
    endtask

    task automatic do_stop();
        @(negedge clk) stop_seen = 1'b1;
        @(negedge clk) stop_seen = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
    endtask

    task automatic do_write(input bit v);
        @(negedge clk) begin flag_wr = 1'b1; flag_wdata = v; end
        @(negedge clk) flag_wr = 1'b0;
    endtask

    task automatic do_dma();
        @(negedge clk) dma_rd = 1'b1;
        @(negedge clk) dma_rd = 1'b0;
    endtask

    task automatic do_soft();
        @(negedge clk) soft_rst = 1'b1;
        @(negedge clk) soft_rst = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        expect_flag(1'b0, "R1 reset");
        idle(1);

        // R2: threshold at 15 ticks
        fifo_level = 5'd2;
        do_stop();
        ticks(14);
        expect_flag(1'b0, "R2 after 14 ticks");
        ticks(1);
        expect_flag(1'b0, "R2 15th tick not yet registered");
        idle(1);
        expect_flag(1'b1, "R2 raised after 15 ticks");

        // R6: invalid clear attempts
        do_write(1'b0);
        idle(1);
        expect_flag(1'b1, "R6 write0 no read, fifo not empty");
        fifo_level = 5'd0;
        do_write(1'b0);
        idle(1);
        expect_flag(1'b1, "R6 write0 without read");
        do_read();
        do_write(1'b1);
        idle(1);
        expect_flag(1'b1, "R6 write1 no effect");
        // R7: valid handshake
        do_write(1'b0);
        expect_flag(1'b0, "R7 cpu clear");

        // R8: fresh window after clear
        fifo_level = 5'd2;
        ticks(14);
        expect_flag(1'b0, "R8 14 ticks after clear");
        ticks(1);
        idle(1);
        expect_flag(1'b1, "R8 re-raise after new window");

        // R9: DMA drain
        do_dma();
        idle(1);
        expect_flag(1'b1, "R9 dma with residue left");
        fifo_level = 5'd0;
        do_dma();
        expect_flag(1'b0, "R9 dma drain clear");

        // R4: empty and at-trigger levels
        do_stop();
        ticks(16);
        idle(2);
        expect_flag(1'b0, "R4 empty fifo");
        fifo_level = 5'd4;
        ticks(2);
        idle(2);
        expect_flag(1'b0, "R4 level equals trigger");
        fifo_level = 5'd9;
        idle(2);
        expect_flag(1'b0, "R4 level above trigger");
        // R5: counter saturated, drop into range
        fifo_level = 5'd3;
        idle(1);
        expect_flag(1'b1, "R5 saturated count sets");

        // R10: soft reset
        do_soft();
        expect_flag(1'b0, "R10 soft reset");

        // R3: stop restarts the window
        fifo_level = 5'd2;
        do_stop();
        ticks(10);
        do_stop();
        ticks(10);
        idle(1);
        expect_flag(1'b0, "R3 stop restarted count");
        ticks(5);
        idle(1);
        expect_flag(1'b1, "R3 window complete after restart");

        // R6: read while flag 0 does not count
        do_soft();
        fifo_level = 5'd1;
        do_read();
        do_stop();
        ticks(15);
        idle(1);
        expect_flag(1'b1, "R6 raised again");
        fifo_level = 5'd0;
        do_write(1'b0);
        idle(1);
        expect_flag(1'b1, "R6 read taken while flag 0 ignored");
        do_read();
        do_write(1'b0);
        expect_flag(1'b0, "R7 clear after proper read");

        idle(3);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule